// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of sixteen general-purpose pins controlled through a small register-mapped bus (byte address, write enable, write data, combinational read data). Software sets each pin as an input or an output, sets the value driven on output pins, and reads back the live level of every pin. Each pin also has an event detector. Per pin, the detector senses either a level or an edge, and the polarity is chosen separately for each kind of sensing. Detected events are held in a sticky status register that software clears by writing zeros to it. The bank raises a single interrupt line while any unmasked status bit is set.

The bus is a plain register port with no handshake. A write takes effect on the rising clock edge where `wr_en` is high. Read data follows `addr` combinationally. A chip places several banks 0x100 bytes apart. Inside a bank, word offsets are byte address divided by four. Several registers only store a value for the rest of the chip: sleep mask, sleep output, fault output, alternate function and sleep configuration. The pins are assumed to be already synchronised to `clk`.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0, and with all pins high the interrupt status stays 0 and `irq` is 0. After reset all pins are inputs, none is masked, and all sense low levels.
- R2: Direction (offset 0x04, 1 = output) drives `pin_oe`. Output value (offset 0x08, 0 = low) drives `pin_out`. Both read back what was written, starting the cycle after the write.
- R3: Offset 0x30 reads the current `pin_in` value. Writes to it are ignored.
- R4: With the trigger type bit at 0 (level), a status bit (offset 0x24) is set on the clock edge where the pin equals the level polarity bit (offset 0x14; 0 = low, 1 = high).
- R5: With the trigger type bit at 1 (edge, offset 0x0C), a status bit is set only on the edge where the pin differs from its value one cycle earlier and now equals the edge polarity bit (offset 0x10; 0 = falling, 1 = rising). A steady pin never sets it.
- R6: Writing the status register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit.
- R7: In level mode, an event that is active in the same cycle as a clear wins, so the bit stays set.
- R8: `irq` is high exactly when some status bit is 1 and its mask bit (offset 0x00, 1 = blocked) is 0. Masking does not stop the status bit from latching.
- R9: Offsets 0x18, 0x1C, 0x20, 0x28 and 0x2C store and read back 16 bits and have no effect on the pins or on `irq`.
- R10: Misaligned addresses and offsets above 0x30 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address within the bank |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pin_in | input | 16 | Synchronised pin levels |
| pin_oe | output | 16 | Output enable per pin |
| pin_out | output | 16 | Output value per pin |
| irq | output | 1 | Bank interrupt |

## Verification
A wrong detector state appears at the 0x24 read port and on `irq` one clock edge after the pin stimulus. For example, a stale previous-pin sample makes a spurious edge event, and a lost sticky bit makes the status fall. A broken write decode shows on the next read of the register that was hit, and for direction and output it also shows at once on `pin_oe` or `pin_out`. Clears that race a live level are checked in the same cycle as the write, because a wrong priority makes the status read 0 right after that write.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_REGS = 13;
  typedef enum logic [3:0] {
    RG_MASK    = 4'd0,
    RG_DIR     = 4'd1,
    RG_OUT     = 4'd2,
    RG_TTYPE   = 4'd3,
    RG_EPOL    = 4'd4,
    RG_LPOL    = 4'd5,
    RG_SLPMASK = 4'd6,
    RG_SLPOUT  = 4'd7,
    RG_FLTOUT  = 4'd8,
    RG_STATUS  = 4'd9,
    RG_ALT     = 4'd10,
    RG_SLPCFG  = 4'd11,
    RG_LEVEL   = 4'd12
  } reg_idx_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  clr_mask,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  ttype_q,
  output logic [NPINS-1:0]  epol_q,
  output logic [NPINS-1:0]  lpol_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [NPINS-1:0] cfg_q [NUM_REGS];
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic             status_wr;

  assign idx       = addr[ADDR_W-1:2];
  assign hit       = (addr[1:0] == 2'b00) && (idx < IDX_W'(NUM_REGS));
  assign status_wr = wr_en && hit && (idx == IDX_W'(RG_STATUS));
  assign clr_mask  = status_wr ? ~wdata : '0;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_cfg
      if (g == int'(RG_STATUS) || g == int'(RG_LEVEL)) begin : g_none
        assign cfg_q[g] = '0;
      end else begin : g_store
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) cfg_q[g] <= '0;
          else if (wr_en && hit && idx == IDX_W'(g)) cfg_q[g] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (hit) begin
      case (idx)
        IDX_W'(RG_STATUS): rdata = status;
        IDX_W'(RG_LEVEL):  rdata = pin_in;
        default:           rdata = cfg_q[idx[3:0]];
      endcase
    end
  end

  assign mask_q  = cfg_q[RG_MASK];
  assign dir_q   = cfg_q[RG_DIR];
  assign out_q   = cfg_q[RG_OUT];
  assign ttype_q = cfg_q[RG_TTYPE];
  assign epol_q  = cfg_q[RG_EPOL];
  assign lpol_q  = cfg_q[RG_LPOL];

  // R10: a write outside the map leaves the direction register untouched
  a_r10_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic edge_mode,
  input  logic edge_pol,
  input  logic level_pol,
  input  logic clr,
  output logic st
);
  logic prev_q;
  logic st_q;
  logic evt;

  assign evt = edge_mode ? ((pin != prev_q) && (pin == edge_pol))
                         : (pin == level_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      st_q   <= 1'b0;
    end else begin
      prev_q <= pin;
      st_q   <= (st_q && !clr) || evt;
    end
  end

  assign st = st_q;

  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && pin == level_pol) |=> st);
  a_r5_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && pin == prev_q && clr) |=> !st);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st && !clr) |=> st);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  pin_out,
  output logic              irq
);
  logic [NPINS-1:0] status, clr_mask, mask_q, dir_q, out_q;
  logic [NPINS-1:0] ttype_q, epol_q, lpol_q;

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .status(status), .clr_mask(clr_mask),
    .mask_q(mask_q), .dir_q(dir_q), .out_q(out_q), .ttype_q(ttype_q),
    .epol_q(epol_q), .lpol_q(lpol_q)
  );

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_pin
      gpio_pin_detect u_det (
        .clk(clk), .rst_n(rst_n), .pin(pin_in[p]), .edge_mode(ttype_q[p]),
        .edge_pol(epol_q[p]), .level_pol(lpol_q[p]), .clr(clr_mask[p]),
        .st(status[p])
      );
    end
  endgenerate

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq     = |(status & ~mask_q);

  a_r2_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h04)) |=> (pin_oe == $past(wdata)));
  a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h08)) |=> (pin_out == $past(wdata)));
endmodule

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] pin_in = 16'hFFFF;
  logic [15:0] pin_oe, pin_out;
  logic        irq;
  int          n_run = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  gpio_bank dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq(irq));

  typedef struct packed { logic [7:0] a; logic [15:0] d; logic [15:0] exp; logic [7:0] req; } vec_t;
  localparam vec_t VECS [10] = '{
    '{8'h04, 16'hA5A5, 16'hA5A5, 8'd2},   // R2 direction
    '{8'h08, 16'h5A5A, 16'h5A5A, 8'd2},   // R2 output
    '{8'h18, 16'h1234, 16'h1234, 8'd9},   // R9 sleep mask
    '{8'h1C, 16'hBEEF, 16'hBEEF, 8'd9},   // R9 sleep out
    '{8'h20, 16'h0F0F, 16'h0F0F, 8'd9},   // R9 fault out
    '{8'h28, 16'hC3C3, 16'hC3C3, 8'd9},   // R9 alternate function
    '{8'h2C, 16'h0002, 16'h0002, 8'd9},   // R9 sleep config
    '{8'h30, 16'h0000, 16'hFFFF, 8'd3},   // R3 level read, write ignored
    '{8'h34, 16'hFFFF, 16'h0000, 8'd10},  // R10 beyond map
    '{8'h06, 16'hFFFF, 16'h0000, 8'd10}   // R10 misaligned
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(20ns * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    tick(3); rst_n = 1'b1; tick(2);
    // R1 reset state
    for (int a = 0; a < 12; a++) begin rd(8'(a * 4), v); chk("R1", v, 16'h0); end
    chk("R1", pin_oe, 16'h0); chk("R1", pin_out, 16'h0); chk("R1", {15'b0, irq}, 16'h0);

    for (int i = 0; i < 10; i++) begin
      wr(VECS[i].a, VECS[i].d);
      rd(VECS[i].a, v);
      n_run++;
      if (v !== VECS[i].exp) begin
        n_fail++;
        $display("FAIL R%0d addr=%h actual=%h expected=%h", VECS[i].req, VECS[i].a, v, VECS[i].exp);
      end
    end
    chk("R2", pin_oe, 16'hA5A5); chk("R2", pin_out, 16'h5A5A);
    chk("R9", {15'b0, irq}, 16'h0);
    rd(8'h00, v); chk("R10", v, 16'h0);
    rd(8'h24, v); chk("R9", v, 16'h0);

    // R4 level low on pin 3
    @(negedge clk); pin_in = 16'hFFF7; tick(1);
    rd(8'h24, v); chk("R4", v, 16'h0008); chk("R8", {15'b0, irq}, 16'h1);
    // R7 clear during active level is overridden
    wr(8'h24, 16'h0000); rd(8'h24, v); chk("R7", v, 16'h0008);
    pin_in = 16'hFFFF; wr(8'h24, 16'h0000); rd(8'h24, v); chk("R6", v, 16'h0000);
    chk("R8", {15'b0, irq}, 16'h0);

    // R8 mask blocks irq but not latching
    wr(8'h00, 16'h0008);
    pin_in = 16'hFFF7; tick(1); pin_in = 16'hFFFF; tick(1);
    rd(8'h24, v); chk("R8", v, 16'h0008); chk("R8", {15'b0, irq}, 16'h0);
    wr(8'h00, 16'h0000); chk("R8", {15'b0, irq}, 16'h1);
    wr(8'h24, 16'h0000);

    // R5 edge mode, falling
    wr(8'h0C, 16'hFFFF);
    pin_in = 16'hFFDF; tick(3);
    rd(8'h24, v); chk("R5", v, 16'h0020);
    wr(8'h24, 16'h0000); tick(2); rd(8'h24, v); chk("R5", v, 16'h0000);
    pin_in = 16'hFFFF; tick(2); rd(8'h24, v); chk("R5", v, 16'h0000);
    // R5 rising on pin 5 with pin 1 falling at once
    wr(8'h10, 16'h0020);
    pin_in = 16'hFFDF; tick(2); wr(8'h24, 16'h0000);
    pin_in = 16'hFFFD; tick(1);
    rd(8'h24, v); chk("R5", v, 16'h0022);
    // R6 partial clear, writes of 1 never set
    wr(8'h24, 16'h0020); rd(8'h24, v); chk("R6", v, 16'h0020);
    wr(8'h24, 16'hFFFF); rd(8'h24, v); chk("R6", v, 16'h0020);
    wr(8'h24, 16'h0000); wr(8'h24, 16'hFFFF); rd(8'h24, v); chk("R6", v, 16'h0000);

    // R4 high-level polarity in level mode
    wr(8'h14, 16'h8000); wr(8'h0C, 16'h7FFF); tick(1);
    rd(8'h24, v); chk("R4", v, 16'h8000);
    rd(8'h30, v); chk("R3", v, 16'hFFFD);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule